// File: doc/BRIEF.md
# Programmable Product-Term Array

This block forms logic terms from two input buses under register control. Each term is the AND of one contribution per input. A 2-bit operation code picks each contribution: a constant low, the input as it is, the input inverted, or a constant high. A wide bank turns 16 inputs into 8 terms. A narrow bank turns 8 inputs into 7 terms.

Software programs one 32-bit word per term through a single-cycle write port. Every word can be read back on the same address bus. The terms are registered on the rising clock edge. They are gated by an activation register that unlocks only on a fixed key word, so a half-programmed array never drives its consumers.

Top module: `aoi_term_array`

## Requirements
- R1: Operation code 0 makes an input contribute constant 0, code 1 passes the input, code 2 inverts it and code 3 makes it contribute constant 1.
- R2: Each term is the AND of all of its per-input contributions, so a term whose inputs all carry code 3 is constant 1 and any code 0 forces it to 0.
- R3: The code for input i sits in bits [2i+1:2i] of the term's word. Wide term t is at address t (0..7) and narrow term t is at address 8+t (8..14).
- R4: The narrow bank has 8 inputs and 7 terms. Bits 31:16 of its words are ignored on write and read back as 0.
- R5: Reading an address returns on rd_data_o, in the same cycle, the word last written there.
- R6: Writing 0x0000F00D to address 15 activates the array and writing 0 deactivates it. Any other value leaves the state unchanged. Address 15 reads back 1 when the array is active and 0 when it is not.
- R7: While the array is inactive, every term output is 0 one clock after that state is sampled, whatever the configuration.
- R8: Term outputs are registered, so a change of input or configuration shows at the outputs one rising edge after it is captured. A configuration written at edge k first affects the outputs at edge k+1.
- R9: Reset clears every configuration word to 0 and deactivates the array, so all terms read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Write strobe for the word at addr_i |
| addr_i | input | 4 | Register address for write and readback |
| wr_data_i | input | 32 | Write data |
| rd_data_o | output | 32 | Combinational readback of addr_i |
| wide_in_i | input | 16 | Inputs of the wide bank |
| narrow_in_i | input | 8 | Inputs of the narrow bank |
| wide_term_o | output | 8 | Registered wide-bank terms |
| narrow_term_o | output | 7 | Registered narrow-bank terms |

## Verification
Readback is combinational, so it is sampled a few nanoseconds after addr_i settles and before any clock edge. A configuration or activation write lands at one edge and reaches the term outputs at the next. The bench therefore checks that a term still shows its old value right after the write edge and its new value one edge later. Input patterns are driven at the falling edge and the terms are compared at the following falling edge, after exactly one rising edge has captured them.

// File: rtl/aoi_pkg.sv
`timescale 1ns/1ps
package aoi_pkg;
  localparam int unsigned WORD_W = 32;
  localparam logic [15:0] ACT_KEY = 16'hF00D;

  typedef enum logic [1:0] {
    OP_ZERO = 2'd0,
    OP_PASS = 2'd1,
    OP_INV  = 2'd2,
    OP_ONE  = 2'd3
  } op_e;

  function automatic logic contrib(input logic sig, input logic [1:0] code);
    logic r;
    case (op_e'(code))
      OP_ZERO: r = 1'b0;
      OP_PASS: r = sig;
      OP_INV:  r = ~sig;
      default: r = 1'b1;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/aoi_key_gate.sv
`timescale 1ns/1ps
module aoi_key_gate
  import aoi_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [WORD_W-1:0] wr_data_i,
  output logic              active_o
);
  logic key_hit, clr_hit;

  assign key_hit = wr_data_i == WORD_W'(ACT_KEY);
  assign clr_hit = wr_data_i == '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 active_o <= 1'b0;
    else if (wr_en_i && key_hit) active_o <= 1'b1;
    else if (wr_en_i && clr_hit) active_o <= 1'b0;
  end

  p_key_on_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && wr_data_i == 32'h0000_F00D |=> active_o);
  p_clear_off_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && wr_data_i == 32'h0 |=> !active_o);
  p_other_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && (wr_data_i == 32'h0000_F00D || wr_data_i == 32'h0)) |=> $stable(active_o));
endmodule

// File: rtl/aoi_term_bank.sv
`timescale 1ns/1ps
module aoi_term_bank #(
  parameter int unsigned N_IN   = 16,
  parameter int unsigned N_TERM = 8,
  localparam int unsigned CFG_W = 2 * N_IN,
  localparam int unsigned IDX_W = (N_TERM > 1) ? $clog2(N_TERM) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              active_i,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [CFG_W-1:0]  wr_data_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [CFG_W-1:0]  rd_data_o,
  input  logic [N_IN-1:0]   sig_i,
  output logic [N_TERM-1:0] term_o
);
  logic [CFG_W-1:0]  cfg_q [N_TERM];
  logic [N_IN-1:0]   contrib_w [N_TERM];
  logic [N_TERM-1:0] term_d;

  for (genvar t = 0; t < N_TERM; t++) begin : g_term
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              cfg_q[t] <= '0;
      else if (wr_en_i && int'(wr_idx_i) == t)  cfg_q[t] <= wr_data_i;
    end

    for (genvar i = 0; i < N_IN; i++) begin : g_in
      assign contrib_w[t][i] = aoi_pkg::contrib(sig_i[i], cfg_q[t][2*i +: 2]);
    end

    assign term_d[t] = &contrib_w[t];

    p_wr_lands_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_en_i && int'(wr_idx_i) == t |=> cfg_q[t] == $past(wr_data_i));
    p_zero_word_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cfg_q[t][1:0] == 2'b00 |=> !term_o[t]);
  end

  always_comb begin
    rd_data_o = '0;
    if (int'(rd_idx_i) < N_TERM) rd_data_o = cfg_q[rd_idx_i];
  end

  // gate with activation, register outputs
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) term_o <= '0;
    else         term_o <= active_i ? term_d : '0;
  end

  p_idle_low_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |=> term_o == '0);
endmodule

// File: rtl/aoi_term_array.sv
`timescale 1ns/1ps
module aoi_term_array
  import aoi_pkg::*;
#(
  parameter int unsigned W_IN   = 16,
  parameter int unsigned W_TERM = 8,
  parameter int unsigned N_IN   = 8,
  parameter int unsigned N_TERM = 7,
  localparam int unsigned ADDR_W = $clog2(W_TERM + N_TERM + 1),
  localparam int unsigned W_CFG  = 2 * W_IN,
  localparam int unsigned N_CFG  = 2 * N_IN,
  localparam int unsigned W_IDX  = (W_TERM > 1) ? $clog2(W_TERM) : 1,
  localparam int unsigned N_IDX  = (N_TERM > 1) ? $clog2(N_TERM) : 1,
  localparam int unsigned KEY_ADDR = (1 << ADDR_W) - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WORD_W-1:0] wr_data_i,
  output logic [WORD_W-1:0] rd_data_o,
  input  logic [W_IN-1:0]   wide_in_i,
  input  logic [N_IN-1:0]   narrow_in_i,
  output logic [W_TERM-1:0] wide_term_o,
  output logic [N_TERM-1:0] narrow_term_o
);
  logic              wide_sel, narrow_sel, key_sel, active;
  logic [ADDR_W-1:0] n_off;
  logic [W_CFG-1:0]  w_rd;
  logic [N_CFG-1:0]  n_rd;

  assign wide_sel   = int'(addr_i) < W_TERM;
  assign narrow_sel = int'(addr_i) >= W_TERM && int'(addr_i) < W_TERM + N_TERM;
  assign key_sel    = int'(addr_i) == KEY_ADDR;
  assign n_off      = addr_i - ADDR_W'(W_TERM);

  aoi_key_gate u_key (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i && key_sel),
    .wr_data_i (wr_data_i),
    .active_o  (active)
  );

  aoi_term_bank #(.N_IN(W_IN), .N_TERM(W_TERM)) u_wide (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .active_i  (active),
    .wr_en_i   (wr_en_i && wide_sel),
    .wr_idx_i  (addr_i[W_IDX-1:0]),
    .wr_data_i (wr_data_i[W_CFG-1:0]),
    .rd_idx_i  (addr_i[W_IDX-1:0]),
    .rd_data_o (w_rd),
    .sig_i     (wide_in_i),
    .term_o    (wide_term_o)
  );

  aoi_term_bank #(.N_IN(N_IN), .N_TERM(N_TERM)) u_narrow (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .active_i  (active),
    .wr_en_i   (wr_en_i && narrow_sel),
    .wr_idx_i  (n_off[N_IDX-1:0]),
    .wr_data_i (wr_data_i[N_CFG-1:0]),
    .rd_idx_i  (n_off[N_IDX-1:0]),
    .rd_data_o (n_rd),
    .sig_i     (narrow_in_i),
    .term_o    (narrow_term_o)
  );

  always_comb begin
    rd_data_o = '0;
    if (wide_sel)        rd_data_o = WORD_W'(w_rd);
    else if (narrow_sel) rd_data_o = WORD_W'(n_rd);
    else if (key_sel)    rd_data_o = WORD_W'(active);
  end

  p_inactive_out_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active |=> wide_term_o == '0 && narrow_term_o == '0);
  p_narrow_hi_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    narrow_sel |-> rd_data_o[31:16] == 16'h0);
endmodule

// File: tb/aoi_term_array_tb.sv
`timescale 1ns/1ps
module aoi_term_array_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [15:0] win = '0;
  logic [7:0]  nin = '0;
  logic [7:0]  wterm;
  logic [6:0]  nterm;

  int errors = 0;
  int checks = 0;
  logic [31:0] wcfg [8];
  logic [31:0] ncfg [7];

  always #5 clk = ~clk;

  aoi_term_array u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
    .wr_data_i(wdata), .rd_data_o(rdata), .wide_in_i(win),
    .narrow_in_i(nin), .wide_term_o(wterm), .narrow_term_o(nterm)
  );

  // {wide inputs, narrow inputs}
  localparam logic [23:0] VEC [10] = '{
    24'hFFFF_FF, 24'h0000_00, 24'hFFFE_FE, 24'h0001_01, 24'h5555_55,
    24'hAAAA_AA, 24'h8001_80, 24'h7FFF_7F, 24'h0002_03, 24'h1234_5A
  };

  function automatic logic model(input logic [31:0] w, input logic [15:0] s, input int n);
    logic r = 1'b1;
    for (int i = 0; i < n; i++) begin
      case (w[2*i +: 2])
        2'd0: r = 1'b0;
        2'd1: r = r & s[i];
        2'd2: r = r & ~s[i];
        default: ;
      endcase
    end
    return r;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input logic [3:0] a, input logic [31:0] exp, input string tag);
    addr = a;
    #1;
    chk(rdata === exp, tag, rdata, exp);
  endtask

  task automatic terms_chk(input string tag);
    logic [7:0] ew;
    logic [6:0] en;
    for (int t = 0; t < 8; t++) ew[t] = model(wcfg[t], win, 16);
    for (int t = 0; t < 7; t++) en[t] = model(ncfg[t], {8'h0, nin}, 8);
    chk(wterm === ew, {tag, " wide"}, 32'(wterm), 32'(ew));
    chk(nterm === en, {tag, " narrow"}, 32'(nterm), 32'(en));
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    wcfg = '{32'h5555_5555, 32'hAAAA_AAAA, 32'hFFFF_FFFF, 32'h0,
             32'hFFFF_FFF9, 32'h7FFF_FFFF, 32'hFFFF_FFFC, 32'h6666_6666};
    ncfg = '{32'h5555, 32'hAAAA, 32'hFFFF, 32'h5555,
             32'hFFFD, 32'hBFFF, 32'h0};
    #23;
    // R9: reset state
    chk(wterm === 8'h0 && nterm === 7'h0, "R9 reset terms", 32'({wterm, nterm}), 32'h0);
    rst_n = 1'b1;
    rd_chk(4'd0, 32'h0, "R9 reset word w0");
    rd_chk(4'd14, 32'h0, "R9 reset word n6");
    rd_chk(4'd15, 32'h0, "R9 reset inactive");

    for (int t = 0; t < 8; t++) wr(4'(t), wcfg[t]);
    for (int t = 0; t < 7; t++) wr(4'(8 + t), (t == 3) ? 32'hFFFF_5555 : ncfg[t]);

    // R7: inactive keeps terms low even with constant-1 terms programmed
    win = 16'hFFFF; nin = 8'hFF;
    @(negedge clk);
    chk(wterm === 8'h0 && nterm === 7'h0, "R7 inactive", 32'({wterm, nterm}), 32'h0);

    // R5 R3 R4: readback
    for (int t = 0; t < 8; t++) rd_chk(4'(t), wcfg[t], "R5 wide readback");
    for (int t = 0; t < 7; t++) rd_chk(4'(8 + t), ncfg[t], "R4 narrow readback upper zero");

    // R6: wrong key ignored, right key activates
    wr(4'd15, 32'h0000_1234);
    rd_chk(4'd15, 32'h0, "R6 non-key ignored");
    @(negedge clk);
    chk(wterm === 8'h0, "R6 non-key terms stay low", 32'(wterm), 32'h0);
    wr(4'd15, 32'h0000_F00D);
    rd_chk(4'd15, 32'h1, "R6 key activates");

    // R1 R2 R3: table walk
    for (int v = 0; v < 10; v++) begin
      @(negedge clk);
      win = VEC[v][23:8]; nin = VEC[v][7:0];
      @(negedge clk);
      terms_chk($sformatf("R1 R2 R3 vec%0d", v));
    end

    // R8: input change visible only after one edge
    @(negedge clk);
    win = 16'hFFFF; nin = 8'hFF;
    @(negedge clk);
    win = 16'h0000;
    #1;
    chk(wterm[0] === 1'b1, "R8 old input held", 32'(wterm[0]), 32'h1);
    @(negedge clk);
    chk(wterm[0] === 1'b0 && wterm[1] === 1'b1, "R8 new input after edge", 32'(wterm[1:0]), 32'h2);

    // R8: config write reaches outputs one edge after it lands
    wr(4'd3, 32'hFFFF_FFFF);
    chk(wterm[3] === 1'b0, "R8 cfg not yet applied", 32'(wterm[3]), 32'h0);
    @(negedge clk);
    chk(wterm[3] === 1'b1, "R8 cfg applied next edge", 32'(wterm[3]), 32'h1);
    wcfg[3] = 32'hFFFF_FFFF;
    terms_chk("R2 all-one term");

    // R6 R7: clear deactivates
    wr(4'd15, 32'h0);
    rd_chk(4'd15, 32'h0, "R6 zero deactivates");
    @(negedge clk);
    chk(wterm === 8'h0 && nterm === 7'h0, "R7 after deactivate", 32'({wterm, nterm}), 32'h0);

    // R9: reset mid-run
    wr(4'd15, 32'h0000_F00D);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(wterm === 8'h0, "R9 reset clears terms", 32'(wterm), 32'h0);
    rd_chk(4'd2, 32'h0, "R9 reset clears config");
    rd_chk(4'd15, 32'h0, "R9 reset deactivates");
    rst_n = 1'b1;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule